// File: doc/BRIEF.md
# Receive Descriptor Ring DMA

This block takes a byte stream of received frames and places each frame into one of a fixed ring of equally sized receive buffers. Every buffer has a 32-bit descriptor kept inside the block. When the last byte of a frame arrives, the block writes the stored length and a status back to that buffer's descriptor. It then advances a 16-bit free-running producer index. Software reads descriptors through a registered read port. It hands buffers back by writing a new value of the 16-bit consumer index. The distance between the two indices is the number of filled buffers.

Two options shape each frame. A header-alignment option leaves two bytes free at the start of the buffer so that the network header lands on a 4-byte boundary; the reported length counts those two bytes. Frames longer than the maximum are cut at the limit and flagged. A pause request (XOFF) output with hysteresis tracks the number of free buffers against two programmable levels. A frame that finds no free buffer is discarded and counted.

Top module: `rx_ring_dma`

## Requirements
- R1: While reset is high and on the cycle after it falls, prod_idx, cons_idx and drop_count read 0, xoff reads 0 and buf_we reads 0.
- R2: For DESC_COUNT cycles after reset the block writes every descriptor with the buffer size (2048) in bits 27:16 and bit 15 (hardware-owned) set, i.e. 32'h0800_8000. A frame whose first byte arrives during this sweep is discarded and drop_count rises by one.
- R3: Byte n (from 0) of an accepted frame is written one clock after it is sampled, with buf_we=1, buf_data equal to the byte, and buf_addr = slot*2048 + pad + n. The slot is prod_idx modulo 256.
- R4: If align_en is 1 when a frame's first byte is sampled, pad is 2 and the reported length includes the 2 bytes; otherwise pad is 0. A change of align_en after the first byte has no effect on that frame.
- R5: On the clock edge that samples an accepted frame's last byte, prod_idx increments by one. At the same edge the slot's descriptor becomes {4'b0, length[11:0], 1'b0, 14'b0, trunc}: bits 27:16 hold the length, bit 15 is cleared and bit 0 is the truncation flag.
- R6: A frame with more than 1536 data bytes stores only the first 1536, reports length 1536 plus pad and sets descriptor bit 0. Bytes past the limit cause no buffer write.
- R7: A write of cons_wdata with cons_we is taken at the next edge only if (cons_wdata - cons_idx) mod 65536 does not exceed the current occupancy (prod_idx - cons_idx) mod 65536. Any other write is ignored.
- R8: A frame whose first byte arrives while the occupancy equals 256 is discarded as a whole. No buffer write happens, the descriptors are unchanged, and drop_count rises by one at that byte's edge.
- R9: With fc_thresh = {low[31:16], high[15:0]} and free = 256 - occupancy, xoff becomes 1 one cycle after free <= low. It becomes 0 one cycle after free >= high, and in between it holds its value.
- R10: The occupancy never exceeds 256, and both indices wrap modulo 65536 while the slot wraps modulo 256.
- R11: desc_rd_data shows the descriptor addressed by desc_rd_idx one clock after the index is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received byte present |
| in_data | input | 8 | Received byte |
| in_last | input | 1 | Byte is the last of its frame |
| align_en | input | 1 | Insert two pad bytes before the frame |
| fc_thresh | input | 32 | Pause levels: low in 31:16, high in 15:0 |
| cons_we | input | 1 | Consumer index write strobe |
| cons_wdata | input | 16 | New consumer index |
| desc_rd_idx | input | 8 | Descriptor read index |
| desc_rd_data | output | 32 | Descriptor read data, one cycle latency |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 19 | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |
| prod_idx | output | 16 | Producer index |
| cons_idx | output | 16 | Consumer index |
| xoff | output | 1 | Pause request |
| drop_count | output | 16 | Discarded frame count |

## Verification
On every cycle the assertions check four things from the port values. The occupancy stays within the ring. The producer index only ever steps by one. No buffer write follows a full ring, and buffer offsets stay inside the allowed span. Every edge of xoff must also be justified by the free count against the matching level. The exact descriptor words, the address of every stored byte, the handling of truncated frames, alignment sampled only at a frame's start and rejected consumer writes can only be shown by the bench's scenarios. Its per-cycle reference model covers ring fill, drop, hysteresis release and index wrap.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int LEN_W      = 12;
  localparam int DESC_W     = 32;
  localparam int THR_W      = 16;
  localparam int PAD_BYTES  = 2;
  localparam int LEN_LSB    = 16;
  localparam int OWN_BIT    = 15;
  localparam int TRUNC_BIT  = 0;

  typedef enum logic [1:0] {
    WR_IDLE = 2'd0,
    WR_TAKE = 2'd1,
    WR_SKIP = 2'd2
  } wr_state_e;

  function automatic logic [DESC_W-1:0] desc_word(input logic [LEN_W-1:0] len,
                                                  input logic own,
                                                  input logic trunc);
    logic [DESC_W-1:0] w;
    w = '0;
    w[LEN_LSB +: LEN_W] = len;
    w[OWN_BIT]          = own;
    w[TRUNC_BIT]        = trunc;
    return w;
  endfunction
endpackage

// File: rtl/rxr_desc_ram.sv
module rxr_desc_ram #(
  parameter int DEPTH = 256,
  parameter int WIDTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    waddr,
  input  logic [WIDTH-1:0] wdata,
  input  logic [AW-1:0]    raddr,
  output logic [WIDTH-1:0] rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/rxr_desc_init.sv
module rxr_desc_init #(
  parameter int DESC_COUNT = 256,
  localparam int AW = $clog2(DESC_COUNT)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          busy,
  output logic          init_we,
  output logic [AW-1:0] init_idx
);
  logic [AW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == AW'(DESC_COUNT - 1)) busy_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign init_we  = busy_q && !rst;
  assign init_idx = cnt_q;
endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl
  import rxr_pkg::*;
#(
  parameter int DESC_COUNT = 256,
  parameter int IDX_W      = 16,
  parameter int DROP_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              frame_done,
  input  logic              frame_drop,
  input  logic              cons_we,
  input  logic [IDX_W-1:0]  cons_wdata,
  input  logic [DESC_W-1:0] fc_thresh,
  output logic [IDX_W-1:0]  prod_idx,
  output logic [IDX_W-1:0]  cons_idx,
  output logic              full,
  output logic              xoff,
  output logic [DROP_W-1:0] drop_count
);
  logic [IDX_W-1:0]  prod_q, cons_q, occ, step;
  logic [IDX_W:0]    free_cnt, lo_lvl, hi_lvl;
  logic [DROP_W-1:0] drop_q;
  logic              xoff_q, cons_ok;

  assign occ      = prod_q - cons_q;
  assign full     = (occ == IDX_W'(DESC_COUNT));
  assign free_cnt = (IDX_W+1)'(DESC_COUNT) - {1'b0, occ};
  assign lo_lvl   = (IDX_W+1)'(fc_thresh[DESC_W-1:THR_W]);
  assign hi_lvl   = (IDX_W+1)'(fc_thresh[THR_W-1:0]);
  assign step     = cons_wdata - cons_q;
  assign cons_ok  = cons_we && (step <= occ);

  always_ff @(posedge clk) begin
    if (rst) begin
      prod_q <= '0;
      cons_q <= '0;
      drop_q <= '0;
      xoff_q <= 1'b0;
    end else begin
      if (frame_done) prod_q <= prod_q + 1'b1;
      if (cons_ok)    cons_q <= cons_wdata;
      if (frame_drop) drop_q <= drop_q + 1'b1;
      if (free_cnt <= lo_lvl)      xoff_q <= 1'b1;
      else if (free_cnt >= hi_lvl) xoff_q <= 1'b0;
    end
  end

  assign prod_idx   = prod_q;
  assign cons_idx   = cons_q;
  assign xoff       = xoff_q;
  assign drop_count = drop_q;
endmodule

// File: rtl/rxr_frame_writer.sv
module rxr_frame_writer
  import rxr_pkg::*;
#(
  parameter int SLOT_W  = 8,
  parameter int OFF_W   = 11,
  parameter int MAX_LEN = 1536
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    in_valid,
  input  logic [7:0]              in_data,
  input  logic                    in_last,
  input  logic                    align_en,
  input  logic                    reject,
  input  logic [SLOT_W-1:0]       slot,
  output logic                    buf_we,
  output logic [SLOT_W+OFF_W-1:0] buf_addr,
  output logic [7:0]              buf_data,
  output logic                    frame_drop,
  output logic                    frame_done,
  output logic [LEN_W-1:0]        done_len,
  output logic                    done_trunc
);
  wr_state_e               state_q;
  logic [LEN_W-1:0]        off_q, cnt_q;
  logic                    trunc_q;
  logic                    we_q;
  logic [SLOT_W+OFF_W-1:0] addr_q;
  logic [7:0]              data_q;

  logic             idle, take, store, room, cur_trunc;
  logic [LEN_W-1:0] cur_off, cur_cnt, new_cnt;
  logic [OFF_W-1:0] buf_off;

  always_comb begin
    idle       = (state_q == WR_IDLE);
    take       = in_valid && ((state_q == WR_TAKE) || (idle && !reject));
    cur_off    = idle ? (align_en ? LEN_W'(PAD_BYTES) : '0) : off_q;
    cur_cnt    = idle ? '0 : cnt_q;
    cur_trunc  = idle ? 1'b0 : trunc_q;
    room       = (cur_cnt < LEN_W'(MAX_LEN));
    store      = take && room;
    new_cnt    = cur_cnt + LEN_W'(store);
    buf_off    = OFF_W'(cur_off + cur_cnt);
    frame_drop = in_valid && idle && reject;
    frame_done = take && in_last;
    done_len   = new_cnt + cur_off;
    done_trunc = cur_trunc | (take && !room);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= WR_IDLE;
      off_q   <= '0;
      cnt_q   <= '0;
      trunc_q <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      we_q <= store;
      if (store) begin
        addr_q <= {slot, buf_off};
        data_q <= in_data;
      end
      if (take) begin
        off_q   <= cur_off;
        cnt_q   <= new_cnt;
        trunc_q <= done_trunc;
      end
      if (in_valid) begin
        unique case (state_q)
          WR_IDLE: begin
            if (in_last)     state_q <= WR_IDLE;
            else if (reject) state_q <= WR_SKIP;
            else             state_q <= WR_TAKE;
          end
          WR_TAKE, WR_SKIP: if (in_last) state_q <= WR_IDLE;
          default: state_q <= WR_IDLE;
        endcase
      end
    end
  end

  assign buf_we   = we_q;
  assign buf_addr = addr_q;
  assign buf_data = data_q;
endmodule

// File: rtl/rx_ring_dma.sv
module rx_ring_dma
  import rxr_pkg::*;
#(
  parameter int DESC_COUNT = 256,
  parameter int BUF_BYTES  = 2048,
  parameter int MAX_LEN    = 1536,
  parameter int IDX_W      = 16,
  parameter int DROP_W     = 16,
  localparam int SLOT_W    = $clog2(DESC_COUNT),
  localparam int OFF_W     = $clog2(BUF_BYTES),
  localparam int ADDR_W    = SLOT_W + OFF_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  input  logic              in_last,
  input  logic              align_en,
  input  logic [31:0]       fc_thresh,
  input  logic              cons_we,
  input  logic [IDX_W-1:0]  cons_wdata,
  input  logic [SLOT_W-1:0] desc_rd_idx,
  output logic [31:0]       desc_rd_data,
  output logic              buf_we,
  output logic [ADDR_W-1:0] buf_addr,
  output logic [7:0]        buf_data,
  output logic [IDX_W-1:0]  prod_idx,
  output logic [IDX_W-1:0]  cons_idx,
  output logic              xoff,
  output logic [DROP_W-1:0] drop_count
);
  localparam logic [DESC_W-1:0] INIT_WORD = desc_word(LEN_W'(BUF_BYTES), 1'b1, 1'b0);

  logic              busy, init_we, full, reject;
  logic [SLOT_W-1:0] init_idx, slot;
  logic              frame_drop, frame_done, done_trunc;
  logic [LEN_W-1:0]  done_len;
  logic              ram_we;
  logic [SLOT_W-1:0] ram_waddr;
  logic [DESC_W-1:0] ram_wdata;

  rxr_desc_init #(.DESC_COUNT(DESC_COUNT)) u_init (
    .clk(clk), .rst(rst), .busy(busy), .init_we(init_we), .init_idx(init_idx)
  );

  rxr_ring_ctrl #(.DESC_COUNT(DESC_COUNT), .IDX_W(IDX_W), .DROP_W(DROP_W)) u_ring (
    .clk(clk), .rst(rst), .frame_done(frame_done), .frame_drop(frame_drop),
    .cons_we(cons_we), .cons_wdata(cons_wdata), .fc_thresh(fc_thresh),
    .prod_idx(prod_idx), .cons_idx(cons_idx), .full(full), .xoff(xoff),
    .drop_count(drop_count)
  );

  assign reject = busy | full;
  assign slot   = prod_idx[SLOT_W-1:0];

  rxr_frame_writer #(.SLOT_W(SLOT_W), .OFF_W(OFF_W), .MAX_LEN(MAX_LEN)) u_wr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .align_en(align_en), .reject(reject), .slot(slot),
    .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
    .frame_drop(frame_drop), .frame_done(frame_done),
    .done_len(done_len), .done_trunc(done_trunc)
  );

  always_comb begin
    ram_we    = init_we | frame_done;
    ram_waddr = init_we ? init_idx : slot;
    ram_wdata = init_we ? INIT_WORD : desc_word(done_len, 1'b0, done_trunc);
  end

  rxr_desc_ram #(.DEPTH(DESC_COUNT), .WIDTH(DESC_W)) u_ram (
    .clk(clk), .we(ram_we), .waddr(ram_waddr), .wdata(ram_wdata),
    .raddr(desc_rd_idx), .rdata(desc_rd_data)
  );
endmodule

// File: rtl/rx_ring_dma_chk.sv
module rx_ring_dma_chk #(
  parameter int DESC_COUNT = 256,
  parameter int BUF_BYTES  = 2048,
  parameter int MAX_LEN    = 1536,
  parameter int IDX_W      = 16,
  parameter int DROP_W     = 16,
  parameter int ADDR_W     = 19
) (
  input logic              clk,
  input logic              rst,
  input logic [31:0]       fc_thresh,
  input logic              buf_we,
  input logic [ADDR_W-1:0] buf_addr,
  input logic [IDX_W-1:0]  prod_idx,
  input logic [IDX_W-1:0]  cons_idx,
  input logic              xoff,
  input logic [DROP_W-1:0] drop_count
);
  localparam int OFF_W = $clog2(BUF_BYTES);
  logic [IDX_W-1:0] occ;
  logic [IDX_W:0]   free_cnt;
  assign occ      = prod_idx - cons_idx;
  assign free_cnt = (IDX_W+1)'(DESC_COUNT) - {1'b0, occ};

  a_r10_occupancy_bound: assert property (@(posedge clk) disable iff (rst)
    occ <= IDX_W'(DESC_COUNT));

  a_r5_prod_single_step: assert property (@(posedge clk) disable iff (rst)
    (prod_idx != $past(prod_idx)) |-> (prod_idx == $past(prod_idx) + 1'b1));

  a_r8_no_write_when_full: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> ($past(occ) < IDX_W'(DESC_COUNT)));

  a_r6_offset_in_span: assert property (@(posedge clk) disable iff (rst)
    buf_we |-> (int'(buf_addr[OFF_W-1:0]) < MAX_LEN + 2));

  a_r8_drop_single_step: assert property (@(posedge clk) disable iff (rst)
    (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + 1'b1));

  a_r9_xoff_rise: assert property (@(posedge clk) disable iff (rst)
    $rose(xoff) |-> ($past(free_cnt) <= (IDX_W+1)'(fc_thresh[31:16])));

  a_r9_xoff_fall: assert property (@(posedge clk) disable iff (rst)
    $fell(xoff) |-> ($past(free_cnt) >= (IDX_W+1)'(fc_thresh[15:0])));

  a_r7_cons_not_past_prod: assert property (@(posedge clk) disable iff (rst)
    (cons_idx != $past(cons_idx)) |->
      ((cons_idx - $past(cons_idx)) <= ($past(prod_idx) - $past(cons_idx))));
endmodule

bind rx_ring_dma rx_ring_dma_chk #(
  .DESC_COUNT(DESC_COUNT), .BUF_BYTES(BUF_BYTES), .MAX_LEN(MAX_LEN),
  .IDX_W(IDX_W), .DROP_W(DROP_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst(rst), .fc_thresh(fc_thresh), .buf_we(buf_we),
  .buf_addr(buf_addr), .prod_idx(prod_idx), .cons_idx(cons_idx),
  .xoff(xoff), .drop_count(drop_count)
);

// File: tb/rx_ring_dma_test.sv
`timescale 1ns/1ps
module rx_ring_dma_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0, in_last = 1'b0, align_en = 1'b0, cons_we = 1'b0;
  logic [7:0]  in_data = '0;
  logic [31:0] fc_thresh = {16'd5, 16'd16};
  logic [15:0] cons_wdata = '0;
  logic [7:0]  desc_rd_idx = '0;
  logic [31:0] desc_rd_data;
  logic        buf_we;
  logic [18:0] buf_addr;
  logic [7:0]  buf_data;
  logic [15:0] prod_idx, cons_idx, drop_count;
  logic        xoff;

  always #2 clk = ~clk;

  rx_ring_dma uut (.*);

  int errors = 0, checks = 0;

  task automatic check(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  int m_prod, m_cons, m_drop, m_state, m_off, m_cnt, m_trunc, m_init_left;
  int m_we, m_addr, m_data;
  bit m_xoff;
  int m_desc [256];

  always @(posedge clk) begin
    int occ, free, slot;
    bit busy, take, nx;
    if (rst) begin
      m_prod = 0; m_cons = 0; m_drop = 0; m_state = 0; m_xoff = 0;
      m_we = 0; m_init_left = 256;
      foreach (m_desc[i]) m_desc[i] = 32'h0800_8000;
    end else begin
      occ  = (m_prod - m_cons) & 16'hffff;
      free = 256 - occ;
      nx   = m_xoff;
      if (free <= 5) nx = 1; else if (free >= 16) nx = 0;
      busy = (m_init_left > 0);
      if (busy) m_init_left--;
      m_we = 0;
      take = 0;
      if (in_valid) begin
        if (m_state == 0) begin
          if (busy || occ == 256) begin
            m_drop = (m_drop + 1) & 16'hffff;
            m_state = in_last ? 0 : 2;
          end else begin
            m_off = align_en ? 2 : 0; m_cnt = 0; m_trunc = 0; take = 1;
          end
        end else if (m_state == 1) take = 1;
        else if (in_last) m_state = 0;
        if (take) begin
          slot = m_prod & 255;
          if (m_cnt < 1536) begin
            m_we = 1; m_addr = slot * 2048 + m_off + m_cnt; m_data = in_data; m_cnt++;
          end else m_trunc = 1;
          if (in_last) begin
            m_desc[slot] = (((m_cnt + m_off) & 12'hfff) << 16) | m_trunc;
            m_prod = (m_prod + 1) & 16'hffff;
            m_state = 0;
          end else m_state = 1;
        end
      end
      if (cons_we && (((cons_wdata - m_cons) & 16'hffff) <= occ)) m_cons = cons_wdata;
      m_xoff = nx;
    end
  end

  // per-cycle comparison away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      check("R5 prod_idx", prod_idx, m_prod);
      check("R7 cons_idx", cons_idx, m_cons);
      check("R9 xoff", xoff, m_xoff);
      check("R8 drop_count", drop_count, m_drop);
      check("R3 buf_we", buf_we, m_we);
      if (buf_we && m_we) begin
        check("R3 buf_addr", buf_addr, m_addr);
        check("R3 buf_data", buf_data, m_data);
      end
    end
  end

  task automatic send_frame(int len, bit al, bit flip_mid, int seed);
    for (int i = 0; i < len; i++) begin
      in_valid = 1'b1;
      in_data  = 8'(seed + i);
      in_last  = (i == len - 1);
      align_en = (flip_mid && i > 0) ? ~al : al;
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0; align_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic write_cons(int v);
    cons_we = 1'b1; cons_wdata = 16'(v);
    @(negedge clk);
    cons_we = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_desc(string tag, int idx, longint exp);
    desc_rd_idx = 8'(idx);
    @(negedge clk);
    check(tag, desc_rd_data, exp);
  endtask

  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 prod reset", prod_idx, 0);
    check("R1 cons reset", cons_idx, 0);
    check("R1 drop reset", drop_count, 0);
    check("R1 xoff reset", xoff, 0);
    check("R1 buf_we reset", buf_we, 0);
    rst = 1'b0;
    // R2: frame during the descriptor sweep is dropped
    send_frame(3, 0, 0, 8'h10);
    check("R2 drop during sweep", drop_count, 1);
    repeat (270) @(negedge clk);
    read_desc("R2 init desc 0", 0, 32'h0800_8000);
    read_desc("R11 init desc 128", 128, 32'h0800_8000);
    read_desc("R2 init desc 255", 255, 32'h0800_8000);
    // R3/R5 plain frames
    send_frame(1, 0, 0, 8'h20);
    read_desc("R5 one byte", 0, 32'h0001_0000);
    send_frame(60, 0, 0, 8'h30);
    read_desc("R5 sixty bytes", 1, 32'h003c_0000);
    // R4 alignment pad and mid-frame change
    send_frame(10, 1, 0, 8'h40);
    read_desc("R4 aligned length", 2, 32'h000c_0000);
    send_frame(12, 0, 1, 8'h50);
    read_desc("R4 align sampled at start", 3, 32'h000c_0000);
    send_frame(8, 1, 1, 8'h58);
    read_desc("R4 align held", 4, 32'h000a_0000);
    // R6 truncation
    send_frame(1540, 0, 0, 8'h60);
    read_desc("R6 truncated", 5, 32'h0600_0001);
    check("R5 prod after six", prod_idx, 6);
    // R7 release all, then an illegal advance
    write_cons(6);
    check("R7 legal write", cons_idx, 6);
    write_cons(9);
    check("R7 write past prod ignored", cons_idx, 6);
    // R8/R9 fill the ring
    for (int k = 0; k < 256; k++) send_frame(1, 0, 0, k);
    check("R10 occupancy full", 16'(prod_idx - cons_idx), 256);
    check("R9 xoff when nearly full", xoff, 1);
    send_frame(4, 0, 0, 8'h77);
    check("R8 drop when full", drop_count, 2);
    check("R8 prod unchanged", prod_idx, 262);
    write_cons(16);
    @(negedge clk);
    check("R9 hysteresis holds", xoff, 1);
    write_cons(22);
    @(negedge clk);
    check("R9 xoff released", xoff, 0);
    // R10 wrap the slot index
    for (int k = 0; k < 12; k++) send_frame(2, k[0], 0, 8'h80 + k);
    check("R10 prod count", prod_idx, 274);
    read_desc("R10 wrapped slot", 17, m_desc[17]);
    check("R10 wrapped desc value", m_desc[17], 32'h0004_0000);
    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule